// File: doc/BRIEF.md
# Handshake Timing Violation Monitor

This block is a synthesizable runtime checker for a request, acknowledge and response interface. It samples the interface on every rising clock edge and enforces five timing contracts. Each contract is started by a specific trigger event, and each has an exact offset in cycles from that trigger. A broken contract sets an error bit that stays set until reset.

For every rule the block keeps two counters: one for how often the trigger occurred and one for how often the rule failed. Software or a debug harness can then tell a rule that held from a rule whose trigger never fired. Cycles without a trigger never produce an error.

Rule index map, used for the bit of `err_flags` and the slot of both counter arrays: 0 late acknowledge, 1 response timeout, 2 address return, 3 burst acknowledge, 4 grant clash. All outputs are registered. An event that is sampled at clock edge E is visible on the outputs right after E.

Top module: `hs_timing_monitor`

## Requirements
- R1: When `req` is sampled high at edge N and `ack` is sampled low at edge N+1, `err_flags[0]` becomes set after edge N+1. When `ack` is high at N+1, no error is raised.
- R2: An `ack` rise (high at N, low at N-1) opens a window. `response` high at any edge from N+1 to N+8 closes the window without error. If the window is still open after N+8, `err_flags[1]` is set after edge N+8. A new `ack` rise while the window is open restarts the window from the new rise, and the old window raises no error.
- R3: A `req` rise at edge N captures `req_addr`. `resp_addr` equal to the captured value at any edge from N+2 to N+17 closes the window. A match at N+1 does not count. With no match by N+17, `err_flags[2]` is set after edge N+17.
- R4: A `req` rise while an address window is still open sets `addr_ovf` and replaces the capture with the new address. The replaced window raises no error.
- R5: `start` at N, `data` at N+1 and `last` at N+2 require `ack` at N+3. Otherwise `err_flags[3]` is set after edge N+3. A broken pattern is not a trigger.
- R6: `grant_a` and `grant_b` both high at an edge sets `err_flags[4]` after that edge. Either grant alone has no effect.
- R7: Cycles in which no trigger is present change no error flag and no counter.
- R8: `hit_cnt[i]` counts the triggers of rule i: each cycle with `req` high, each `ack` rise, each `req` rise, each completed burst pattern, and each grant clash.
- R9: `fail_cnt[i]` counts the failures of rule i. Both counter arrays are CNT_W bits wide (16 by default) and saturate at all ones.
- R10: While `rst` is high, all flags, counters and `addr_ovf` clear and any open window is discarded. Error flags otherwise stay set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req | input | 1 | Request |
| ack | input | 1 | Acknowledge |
| response | input | 1 | Response strobe |
| start | input | 1 | Burst first beat marker |
| data | input | 1 | Burst middle beat marker |
| last | input | 1 | Burst final beat marker |
| req_addr | input | ADDR_W | Address presented with a request |
| resp_addr | input | ADDR_W | Address returned with a response |
| grant_a | input | 1 | First grant line |
| grant_b | input | 1 | Second grant line |
| err_flags | output | NRULE | Sticky per-rule error bits |
| addr_ovf | output | 1 | Sticky address capture overflow |
| hit_cnt | output | NRULE x CNT_W | Per-rule trigger counters |
| fail_cnt | output | NRULE x CNT_W | Per-rule failure counters |

## Verification
The hardest cases to reach are the window boundaries. These are a response on exactly the eighth cycle, an address match on exactly offset 17, and the interaction between a restarted window and the instant at which the old window would have expired. The stimulus drives each scenario cycle by cycle from a fresh reset. It places the closing event on the last legal cycle and checks the state one cycle before and at the deadline, so that an off-by-one in either direction changes a flag. Counter saturation is reached by holding a grant clash for more than 65,536 cycles.

// File: rtl/hs_mon_pkg.sv
package hs_mon_pkg;
  localparam int NRULE      = 5;
  localparam int RULE_ACK   = 0;
  localparam int RULE_RSP   = 1;
  localparam int RULE_ADDR  = 2;
  localparam int RULE_BURST = 3;
  localparam int RULE_GRANT = 4;
endpackage

// File: rtl/hs_sat_counter.sv
module hs_sat_counter #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc,
  output logic [W-1:0] count
);
  always_ff @(posedge clk) begin
    if (rst)
      count <= '0;
    else if (inc && (count != {W{1'b1}}))
      count <= count + 1'b1;
  end
endmodule

// File: rtl/hs_window_tracker.sv
// One open window: armed at offset 0, satisfied by hit at offsets MIN..MAX.
module hs_window_tracker #(
  parameter int MIN_OFS = 1,
  parameter int MAX_OFS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic arm,
  input  logic hit,
  output logic busy,
  output logic expire
);
  localparam int OFS_W = $clog2(MAX_OFS + 1);
  localparam logic [OFS_W-1:0] LAST = OFS_W'(MAX_OFS);

  logic [OFS_W-1:0] ofs_q;
  logic             busy_q;
  logic             met;

  generate
    if (MIN_OFS <= 1) begin : g_any
      assign met = hit;
    end else begin : g_min
      assign met = hit && (ofs_q >= OFS_W'(MIN_OFS));
    end
  endgenerate

  // a re-arm at the deadline replaces the window, so no expiry is reported
  assign expire = busy_q && !arm && !met && (ofs_q == LAST);
  assign busy   = busy_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      ofs_q  <= '0;
    end else if (arm) begin
      busy_q <= 1'b1;
      ofs_q  <= OFS_W'(1);
    end else if (busy_q) begin
      if (met || (ofs_q == LAST))
        busy_q <= 1'b0;
      else
        ofs_q <= ofs_q + 1'b1;
    end
  end
endmodule

// File: rtl/hs_timing_monitor.sv
module hs_timing_monitor
  import hs_mon_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int CNT_W    = 16,
  parameter int RSP_WIN  = 8,
  parameter int ADDR_MIN = 2,
  parameter int ADDR_MAX = 17
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        req,
  input  logic                        ack,
  input  logic                        response,
  input  logic                        start,
  input  logic                        data,
  input  logic                        last,
  input  logic [ADDR_W-1:0]           req_addr,
  input  logic [ADDR_W-1:0]           resp_addr,
  input  logic                        grant_a,
  input  logic                        grant_b,
  output logic [NRULE-1:0]            err_flags,
  output logic                        addr_ovf,
  output logic [NRULE-1:0][CNT_W-1:0] hit_cnt,
  output logic [NRULE-1:0][CNT_W-1:0] fail_cnt
);
  logic              req_q, ack_q;
  logic              beat1_q, beat2_q, burst_due_q;
  logic [ADDR_W-1:0] cap_q;
  logic              req_rise, ack_rise, burst_seen;
  logic              rsp_expire, addr_expire, addr_busy, rsp_busy;
  logic [NRULE-1:0]  trig, fail;

  assign req_rise   = req & ~req_q;
  assign ack_rise   = ack & ~ack_q;
  assign burst_seen = beat2_q & last;

  always_ff @(posedge clk) begin
    if (rst) begin
      req_q       <= 1'b0;
      ack_q       <= 1'b0;
      beat1_q     <= 1'b0;
      beat2_q     <= 1'b0;
      burst_due_q <= 1'b0;
      cap_q       <= '0;
    end else begin
      req_q       <= req;
      ack_q       <= ack;
      beat1_q     <= start;
      beat2_q     <= beat1_q & data;
      burst_due_q <= burst_seen;
      if (req_rise)
        cap_q <= req_addr;
    end
  end

  hs_window_tracker #(.MIN_OFS(1), .MAX_OFS(RSP_WIN)) u_rsp_win (
    .clk    (clk),
    .rst    (rst),
    .arm    (ack_rise),
    .hit    (response),
    .busy   (rsp_busy),
    .expire (rsp_expire)
  );

  hs_window_tracker #(.MIN_OFS(ADDR_MIN), .MAX_OFS(ADDR_MAX)) u_addr_win (
    .clk    (clk),
    .rst    (rst),
    .arm    (req_rise),
    .hit    (resp_addr == cap_q),
    .busy   (addr_busy),
    .expire (addr_expire)
  );

  always_comb begin
    trig = '0;
    fail = '0;
    trig[RULE_ACK]   = req;
    fail[RULE_ACK]   = req_q & ~ack;
    trig[RULE_RSP]   = ack_rise;
    fail[RULE_RSP]   = rsp_expire;
    trig[RULE_ADDR]  = req_rise;
    fail[RULE_ADDR]  = addr_expire;
    trig[RULE_BURST] = burst_seen;
    fail[RULE_BURST] = burst_due_q & ~ack;
    trig[RULE_GRANT] = grant_a & grant_b;
    fail[RULE_GRANT] = grant_a & grant_b;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flags <= '0;
      addr_ovf  <= 1'b0;
    end else begin
      err_flags <= err_flags | fail;
      addr_ovf  <= addr_ovf | (req_rise & addr_busy);
    end
  end

  generate
    for (genvar i = 0; i < NRULE; i++) begin : g_cnt
      hs_sat_counter #(.W(CNT_W)) u_hit (
        .clk (clk), .rst (rst), .inc (trig[i]), .count (hit_cnt[i])
      );
      hs_sat_counter #(.W(CNT_W)) u_fail (
        .clk (clk), .rst (rst), .inc (fail[i]), .count (fail_cnt[i])
      );
    end
  endgenerate

  logic unused_ok;
  assign unused_ok = rsp_busy;
endmodule

// File: rtl/hs_timing_monitor_chk.sv
module hs_timing_monitor_chk
  import hs_mon_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        req,
  input logic                        ack,
  input logic                        start,
  input logic                        data,
  input logic                        last,
  input logic                        grant_a,
  input logic                        grant_b,
  input logic [NRULE-1:0]            err_flags,
  input logic                        addr_ovf,
  input logic [NRULE-1:0][CNT_W-1:0] hit_cnt,
  input logic [NRULE-1:0][CNT_W-1:0] fail_cnt
);
  // R1: a request not followed by ack on the next edge is flagged one edge later
  a_r1_ack_late: assert property (@(posedge clk) disable iff (rst)
    (req ##1 !ack) |=> err_flags[RULE_ACK]);

  // R5: a completed burst pattern without ack on the following edge
  a_r5_burst_ack: assert property (@(posedge clk) disable iff (rst)
    (start ##1 data ##1 last ##1 !ack) |=> err_flags[RULE_BURST]);

  // R6: simultaneous grants are flagged after the same edge
  a_r6_grant_clash: assert property (@(posedge clk) disable iff (rst)
    (grant_a && grant_b) |=> err_flags[RULE_GRANT]);

  // R4: the overflow bit rises only after an edge that sampled req high
  a_r4_ovf_cause: assert property (@(posedge clk) disable iff (rst)
    $rose(addr_ovf) |-> $past(req));

  // R10: flags never clear outside reset
  a_r10_sticky: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> ((err_flags & $past(err_flags)) == $past(err_flags)));

  // R10: reset clears all status
  a_r10_reset_clear: assert property (@(posedge clk)
    rst |=> (err_flags == '0 && !addr_ovf));

  generate
    for (genvar i = 0; i < NRULE; i++) begin : g_cnt_chk
      // R9: failures never outnumber triggers
      a_r9_fail_le_hit: assert property (@(posedge clk) disable iff (rst)
        1'b1 |-> (fail_cnt[i] <= hit_cnt[i]));
      // R9: a saturated trigger counter holds
      a_r9_hit_sat: assert property (@(posedge clk) disable iff (rst)
        (hit_cnt[i] == {CNT_W{1'b1}}) |=> (hit_cnt[i] == {CNT_W{1'b1}}));
    end
  endgenerate
endmodule

bind hs_timing_monitor hs_timing_monitor_chk #(.CNT_W(CNT_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req       (req),
  .ack       (ack),
  .start     (start),
  .data      (data),
  .last      (last),
  .grant_a   (grant_a),
  .grant_b   (grant_b),
  .err_flags (err_flags),
  .addr_ovf  (addr_ovf),
  .hit_cnt   (hit_cnt),
  .fail_cnt  (fail_cnt)
);

// File: tb/tb_hs_timing_monitor.sv
`timescale 1ns/1ps
module tb_hs_timing_monitor;
  localparam int AW = 32;
  localparam int CW = 16;
  localparam int NR = 5;
  localparam logic [7:0] REQ = 8'h01, ACK = 8'h02, RSP = 8'h04, STA = 8'h08,
                         DAT = 8'h10, LST = 8'h20, GA = 8'h40, GB = 8'h80;
  localparam logic [AW-1:0] ADR_A = 32'hA5A5_0001, ADR_B = 32'h5A5A_0002;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req = 0, ack = 0, response = 0, start = 0, data = 0, last = 0;
  logic grant_a = 0, grant_b = 0;
  logic [AW-1:0] req_addr = '0, resp_addr = '0;
  logic [NR-1:0] err_flags;
  logic addr_ovf;
  logic [NR-1:0][CW-1:0] hit_cnt, fail_cnt;

  int tests = 0;
  int fails = 0;

  always #2.5 clk = ~clk;

  hs_timing_monitor #(.ADDR_W(AW), .CNT_W(CW)) dut (
    .clk (clk), .rst (rst), .req (req), .ack (ack), .response (response),
    .start (start), .data (data), .last (last), .req_addr (req_addr),
    .resp_addr (resp_addr), .grant_a (grant_a), .grant_b (grant_b),
    .err_flags (err_flags), .addr_ovf (addr_ovf),
    .hit_cnt (hit_cnt), .fail_cnt (fail_cnt)
  );

  typedef struct {
    string         tag;
    logic [NR-1:0] fl;
    logic          ov;
    int            h[NR];
    int            f[NR];
  } exp_t;

  exp_t q[$];

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic drive(input logic [7:0] v);
    req = v[0]; ack = v[1]; response = v[2]; start = v[3];
    data = v[4]; last = v[5]; grant_a = v[6]; grant_b = v[7];
  endtask

  // expectation for the state right after the next rising edge
  task automatic push(input string tag, input logic [NR-1:0] fl, input logic ov,
                      input int h0, input int h1, input int h2, input int h3, input int h4,
                      input int f0, input int f1, input int f2, input int f3, input int f4);
    exp_t e;
    e.tag = tag; e.fl = fl; e.ov = ov;
    e.h[0] = h0; e.h[1] = h1; e.h[2] = h2; e.h[3] = h3; e.h[4] = h4;
    e.f[0] = f0; e.f[1] = f1; e.f[2] = f2; e.f[3] = f3; e.f[4] = f4;
    q.push_back(e);
  endtask

  task automatic do_reset();
    drive(8'h00);
    req_addr = '0; resp_addr = '0;
    rst = 1'b1;
    tick(); tick();
    rst = 1'b0;
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
  endtask

  // monitor: compare one expectation per cycle, 1 ns after the edge
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (q.size() > 0) begin
        exp_t e;
        bit bad;
        e = q.pop_front();
        bad = 0;
        if (err_flags !== e.fl) begin
          $display("FAIL %s: err_flags actual=%b expected=%b", e.tag, err_flags, e.fl);
          bad = 1;
        end
        if (addr_ovf !== e.ov) begin
          $display("FAIL %s: addr_ovf actual=%b expected=%b", e.tag, addr_ovf, e.ov);
          bad = 1;
        end
        for (int i = 0; i < NR; i++) begin
          if (hit_cnt[i] !== CW'(e.h[i])) begin
            $display("FAIL %s: hit_cnt[%0d] actual=%0d expected=%0d", e.tag, i, hit_cnt[i], e.h[i]);
            bad = 1;
          end
          if (fail_cnt[i] !== CW'(e.f[i])) begin
            $display("FAIL %s: fail_cnt[%0d] actual=%0d expected=%0d", e.tag, i, fail_cnt[i], e.f[i]);
            bad = 1;
          end
        end
        tests++;
        if (bad) fails++;
      end
    end
  end

  // watchdog
  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    $display("FAIL watchdog R10: cycles actual=190000 expected=fewer");
    summary();
    $finish;
  end

  initial begin
    tick();
    // R10: reset state
    drive(8'h00);
    push("R10 reset state", 5'b0, 0, 0,0,0,0,0, 0,0,0,0,0);
    tick(); tick();
    rst = 1'b0;

    // R1 pass, R8 trigger counts
    do_reset();
    req_addr = ADR_A; drive(REQ); tick();
    drive(ACK); push("R1 ack next cycle / R8", 5'b0, 0, 1,1,1,0,0, 0,0,0,0,0); tick();

    // R1 fail
    do_reset();
    drive(REQ); tick();
    drive(8'h00); push("R1 ack missing", 5'b00001, 0, 1,0,1,0,0, 1,0,0,0,0); tick();

    // R2 pass on last legal cycle, then no late failure
    do_reset();
    drive(ACK); tick();
    drive(8'h00); repeat (7) tick();
    drive(RSP); push("R2 response at N+8", 5'b0, 0, 0,1,0,0,0, 0,0,0,0,0); tick();
    drive(8'h00); repeat (9) tick();
    push("R2 window closed", 5'b0, 0, 0,1,0,0,0, 0,0,0,0,0); tick();

    // R2 timeout at N+8, not before
    do_reset();
    drive(ACK); tick();
    drive(8'h00); repeat (6) tick();
    push("R2 no timeout at N+7", 5'b0, 0, 0,1,0,0,0, 0,0,0,0,0); tick();
    push("R2 timeout at N+8", 5'b00010, 0, 0,1,0,0,0, 0,1,0,0,0); tick();

    // R2 restart on a second ack rise
    do_reset();
    drive(ACK); tick();
    drive(8'h00); repeat (4) tick();
    drive(ACK); tick();
    drive(8'h00); repeat (7) tick();
    drive(RSP); push("R2 restarted window", 5'b0, 0, 0,2,0,0,0, 0,0,0,0,0); tick();

    // R3 match at offset 2
    do_reset();
    req_addr = ADR_A; drive(REQ); tick();
    drive(ACK); tick();
    resp_addr = ADR_A; drive(RSP);
    push("R3 match at offset 2", 5'b0, 0, 1,1,1,0,0, 0,0,0,0,0); tick();
    resp_addr = '0; drive(8'h00); repeat (19) tick();
    push("R3 no later failure", 5'b0, 0, 1,1,1,0,0, 0,0,0,0,0); tick();

    // R3 match at offset 1 ignored, timeout at 17
    do_reset();
    req_addr = ADR_A; drive(REQ); tick();
    resp_addr = ADR_A; drive(ACK); tick();
    resp_addr = '0; drive(RSP); tick();
    drive(8'h00); repeat (13) tick();
    push("R3 no failure at N+16", 5'b0, 0, 1,1,1,0,0, 0,0,0,0,0); tick();
    push("R3 failure at N+17", 5'b00100, 0, 1,1,1,0,0, 0,0,1,0,0); tick();

    // R3 match exactly at offset 17
    do_reset();
    req_addr = ADR_A; drive(REQ); tick();
    drive(ACK); tick();
    drive(RSP); tick();
    drive(8'h00); repeat (14) tick();
    resp_addr = ADR_A;
    push("R3 match at offset 17", 5'b0, 0, 1,1,1,0,0, 0,0,0,0,0); tick();
    resp_addr = '0; repeat (4) tick();
    push("R3 closed after 17", 5'b0, 0, 1,1,1,0,0, 0,0,0,0,0); tick();

    // R4 overflow, capture replaced
    do_reset();
    req_addr = ADR_A; drive(REQ); tick();
    drive(ACK); tick();
    req_addr = ADR_B; drive(REQ); tick();
    drive(ACK); tick();
    resp_addr = ADR_B; drive(RSP);
    push("R4 overflow and new capture", 5'b0, 1, 2,2,2,0,0, 0,0,0,0,0); tick();
    resp_addr = '0; drive(8'h00); repeat (24) tick();
    push("R4 old capture dropped", 5'b0, 1, 2,2,2,0,0, 0,0,0,0,0); tick();

    // R5 burst pass
    do_reset();
    drive(STA); tick();
    drive(DAT); tick();
    drive(LST); tick();
    drive(ACK); push("R5 burst acked", 5'b0, 0, 0,1,0,1,0, 0,0,0,0,0); tick();
    drive(RSP); tick();

    // R5 burst fail
    do_reset();
    drive(STA); tick();
    drive(DAT); tick();
    drive(LST); tick();
    drive(8'h00); push("R5 burst not acked", 5'b01000, 0, 0,0,0,1,0, 0,0,0,1,0); tick();

    // R7 broken pattern is no trigger
    do_reset();
    drive(STA); tick();
    drive(8'h00); tick();
    drive(LST); tick();
    drive(8'h00); push("R7 broken burst", 5'b0, 0, 0,0,0,0,0, 0,0,0,0,0); tick();

    // R6 single grants ignored, clash flagged
    do_reset();
    drive(GA); tick();
    drive(GB); push("R6 single grant ignored", 5'b0, 0, 0,0,0,0,0, 0,0,0,0,0); tick();
    drive(GA | GB); push("R6 grant clash", 5'b10000, 0, 0,0,0,0,1, 0,0,0,0,1); tick();

    // R9 saturation
    do_reset();
    drive(GA | GB); repeat (65539) tick();
    push("R9 counters saturate", 5'b10000, 0, 0,0,0,0,65535, 0,0,0,0,65535); tick();
    drive(8'h00); tick();

    // R10 reset discards an open window and clears status
    drive(ACK); tick();
    drive(8'h00); repeat (3) tick();
    do_reset();
    drive(8'h00); repeat (10) tick();
    push("R10 window discarded", 5'b0, 0, 0,0,0,0,0, 0,0,0,0,0); tick();

    wait (q.size() == 0);
    @(posedge clk); #2;
    summary();
    $finish;
  end
endmodule